// File: doc/BRIEF.md
# Interrupt Request Flag and Enable Unit

This block holds the latched interrupt requests of a small controller and the enables that gate them. Six hardware sources can raise a flag: four external request pins, the wrap of an 8-bit timer count from its maximum back to zero, and a direct-transfer event (a sleep command issued while the direct-transfer control input is high). A raised flag stays raised until software writes a zero to that bit through a simple address/strobe register bus. Taking an interrupt does not clear it.

Each external pin passes through a synchronizer. A per-pin select input chooses whether a rising or a falling edge of the synchronized level sets the flag. The flag register and the pin-enable register are read combinationally over the bus. Each flag is ANDed with its enable, and the result drives a registered per-source request output. A combined request output is the OR of all of them. The enables for the timer and direct-transfer sources come from outside the block.

Top module: `intflag_unit`

## Requirements
- R1: After reset the flag register (address 0) reads 0x30, the enable register (address 1) reads 0x10, and every request output is 0.
- R2: With its edge select at 1 (rising), a rising edge on external pin n sets flag bit n (bit 3 down to bit 0 for pins 3 to 0) within 4 clocks. A falling edge on that pin sets nothing.
- R3: With its edge select at 0 (falling), a falling edge on pin n sets flag bit n within 4 clocks. A rising edge on that pin sets nothing.
- R4: Flag bit 6 is set the cycle after the timer count input goes from 0xFF to 0x00. No other change of the count sets it.
- R5: Flag bit 7 is set when the sleep command and the direct-transfer control input are both 1 at a clock edge. The sleep command alone does not set it.
- R6: Writing 0 to a flag bit at address 0 clears that flag. Writing 1 leaves it unchanged.
- R7: Flag register bits 5 and 4 always read 1, whatever is written to them.
- R8: When a set event and a write-0 clear hit the same flag in the same cycle, the flag ends up set.
- R9: Enable register bits 3..0 hold the written value, bit 4 always reads 1, and bits 7..5 always read 0 and ignore writes.
- R10: One cycle after a flag and its enable are both 1, the matching request output is 1. The pins use the enable register, the timer uses the timer enable input, and the direct transfer uses the direct-transfer enable input. The combined output is the OR of the six request outputs.
- R11: A set flag stays set with no write-0 to it, however long the request has been visible.
- R12: The read data is 0 whenever the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | Register select: 0 flags, 1 pin enables |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| irq_pin | input | 4 | External request pins |
| irq_rise_sel | input | 4 | Per-pin edge select, 1 rising, 0 falling |
| tmr_count | input | 8 | Current timer count |
| sleep_cmd | input | 1 | Sleep command strobe |
| xfer_on | input | 1 | Direct-transfer control level |
| tmr_ien | input | 1 | Timer request enable |
| xfer_ien | input | 1 | Direct-transfer request enable |
| req_irq | output | 4 | Per-pin request outputs |
| req_tmr | output | 1 | Timer request output |
| req_xfer | output | 1 | Direct-transfer request output |
| req_any | output | 1 | OR of all request outputs |

## Verification
A hardware set event and a software write-0 clear can hit the same flag in the same cycle. The bench first raises the direct-transfer flag and the pin flags. In a single cycle it then drives the sleep command with the control input high and also writes 0x00 to the flag register. The bench reads the result back: the direct-transfer flag must still be 1, and the pin flags, which had no set event, must be 0. It repeats the collision for the timer flag by landing the 0xFF to 0x00 wrap on the clearing write.

// File: rtl/intflag_pkg.sv
package intflag_pkg;
  localparam int REG_W     = 8;
  localparam int NIRQ      = 4;
  localparam int NSRC      = NIRQ + 2;
  localparam int REG_TMR   = 6;
  localparam int REG_XFER  = 7;
  localparam int SRC_TMR   = NIRQ;
  localparam int SRC_XFER  = NIRQ + 1;
  localparam logic [REG_W-1:0] FLAG_RST_VAL = 8'h30;
  localparam logic [REG_W-1:0] FLAG_ONES    = 8'h30;
  localparam logic [REG_W-1:0] ENA_ONES     = 8'h10;

  typedef enum logic {
    SEL_FLAG = 1'b0,
    SEL_ENA  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/ifr_pin_edge.sv
module ifr_pin_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_in,
  input  logic rise_sel,
  output logic edge_hit
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_in};
      last_q <= sync_q[TOP];
    end
  end

  always_comb begin
    if (rise_sel) edge_hit = sync_q[TOP] & ~last_q;
    else          edge_hit = ~sync_q[TOP] & last_q;
  end
endmodule

// File: rtl/ifr_wrap_detect.sv
module ifr_wrap_detect #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] count_in,
  output logic             wrapped
);
  logic [CNT_W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= count_in;
  end

  assign wrapped = (prev_q == {CNT_W{1'b1}}) && (count_in == '0);
endmodule

// File: rtl/ifr_flag_bank.sv
module ifr_flag_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] flags
);
  logic [N-1:0] flag_r;

  generate
    for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst)             flag_r[i] <= 1'b0;
        else if (set_vec[i]) flag_r[i] <= 1'b1;
        else if (clr_vec[i]) flag_r[i] <= 1'b0;
      end
    end
  endgenerate

  assign flags = flag_r;
endmodule

// File: rtl/intflag_unit.sv
module intflag_unit
  import intflag_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [NIRQ-1:0]   irq_pin,
  input  logic [NIRQ-1:0]   irq_rise_sel,
  input  logic [CNT_W-1:0]  tmr_count,
  input  logic              sleep_cmd,
  input  logic              xfer_on,
  input  logic              tmr_ien,
  input  logic              xfer_ien,
  output logic [NIRQ-1:0]   req_irq,
  output logic              req_tmr,
  output logic              req_xfer,
  output logic              req_any
);
  logic [NSRC-1:0] set_vec;
  logic [NSRC-1:0] clr_vec;
  logic [NSRC-1:0] flag_q;
  logic [NIRQ-1:0] ien_q;
  logic [NIRQ-1:0] pin_hit;
  logic            tmr_wrap;
  logic            wr_flag;
  logic            wr_ena;
  logic [REG_W-1:0] flag_view;
  logic [REG_W-1:0] ena_view;
  logic [NSRC-1:0] gate_en;

  generate
    for (genvar p = 0; p < NIRQ; p++) begin : g_pin
      ifr_pin_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .pin_in   (irq_pin[p]),
        .rise_sel (irq_rise_sel[p]),
        .edge_hit (pin_hit[p])
      );
    end
  endgenerate

  ifr_wrap_detect #(.CNT_W(CNT_W)) u_wrap (
    .clk      (clk),
    .rst      (rst),
    .count_in (tmr_count),
    .wrapped  (tmr_wrap)
  );

  assign wr_flag = bus_wr && (reg_sel_e'(bus_addr) == SEL_FLAG);
  assign wr_ena  = bus_wr && (reg_sel_e'(bus_addr) == SEL_ENA);

  assign set_vec = {sleep_cmd & xfer_on, tmr_wrap, pin_hit};
  assign clr_vec = {NSRC{wr_flag}} &
                   ~{bus_wdata[REG_XFER], bus_wdata[REG_TMR], bus_wdata[NIRQ-1:0]};

  ifr_flag_bank #(.N(NSRC)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .flags   (flag_q)
  );

  always_ff @(posedge clk) begin
    if (rst)         ien_q <= '0;
    else if (wr_ena) ien_q <= bus_wdata[NIRQ-1:0];
  end

  always_comb begin
    flag_view                = FLAG_ONES;
    flag_view[REG_XFER]      = flag_q[SRC_XFER];
    flag_view[REG_TMR]       = flag_q[SRC_TMR];
    flag_view[NIRQ-1:0]      = flag_q[NIRQ-1:0];
    ena_view                 = ENA_ONES;
    ena_view[NIRQ-1:0]       = ien_q;
  end

  always_comb begin
    if (!bus_rd)                                   bus_rdata = '0;
    else if (reg_sel_e'(bus_addr) == SEL_FLAG)     bus_rdata = flag_view;
    else                                           bus_rdata = ena_view;
  end

  assign gate_en = {xfer_ien, tmr_ien, ien_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      req_irq  <= '0;
      req_tmr  <= 1'b0;
      req_xfer <= 1'b0;
      req_any  <= 1'b0;
    end else begin
      req_irq  <= flag_q[NIRQ-1:0] & ien_q;
      req_tmr  <= flag_q[SRC_TMR] & tmr_ien;
      req_xfer <= flag_q[SRC_XFER] & xfer_ien;
      req_any  <= |(flag_q & gate_en);
    end
  end
endmodule

// File: rtl/intflag_chk.sv
module intflag_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_addr,
  input logic       bus_rd,
  input logic       bus_wr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic [7:0] tmr_count,
  input logic       sleep_cmd,
  input logic       xfer_on,
  input logic [5:0] flag_q,
  input logic [3:0] ien_q,
  input logic [3:0] req_irq,
  input logic       req_tmr,
  input logic       req_xfer,
  input logic       req_any
);
  assert_rsv_ones_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_addr) |-> (bus_rdata[5:4] == 2'b11));

  assert_ena_fixed_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr) |-> (bus_rdata[7:4] == 4'b0001));

  assert_idle_read_R12: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |-> (bus_rdata == 8'h00));

  assert_wrap_sets_R4: assert property (@(posedge clk) disable iff (rst)
    (tmr_count == 8'h00 && $past(tmr_count) == 8'hFF && !$past(rst)) |=> flag_q[4]);

  assert_xfer_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (sleep_cmd && xfer_on) |=> flag_q[5]);

  assert_xfer_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q[5]) |-> $past(sleep_cmd && xfer_on));

  assert_persist_R11: assert property (@(posedge clk) disable iff (rst)
    (flag_q[4] && !(bus_wr && !bus_addr && !bus_wdata[6])) |=> flag_q[4]);

  assert_req_gate_R10: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (req_irq == $past(flag_q[3:0] & ien_q)));

  assert_req_or_R10: assert property (@(posedge clk) disable iff (rst)
    req_any == (|req_irq || req_tmr || req_xfer));
endmodule

bind intflag_unit intflag_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .tmr_count (tmr_count),
  .sleep_cmd (sleep_cmd),
  .xfer_on   (xfer_on),
  .flag_q    (flag_q),
  .ien_q     (ien_q),
  .req_irq   (req_irq),
  .req_tmr   (req_tmr),
  .req_xfer  (req_xfer),
  .req_any   (req_any)
);

// File: tb/intflag_unit_tb.sv
module intflag_unit_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_addr = 1'b0;
  logic       bus_rd = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [3:0] irq_pin = 4'h0;
  logic [3:0] irq_rise_sel = 4'hF;
  logic [7:0] tmr_count = 8'h00;
  logic       sleep_cmd = 1'b0;
  logic       xfer_on = 1'b0;
  logic       tmr_ien = 1'b0;
  logic       xfer_ien = 1'b0;
  logic [3:0] req_irq;
  logic       req_tmr;
  logic       req_xfer;
  logic       req_any;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] rv;

  always #10 clk = ~clk;

  intflag_unit u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pin(irq_pin),
    .irq_rise_sel(irq_rise_sel), .tmr_count(tmr_count), .sleep_cmd(sleep_cmd),
    .xfer_on(xfer_on), .tmr_ien(tmr_ien), .xfer_ien(xfer_ien),
    .req_irq(req_irq), .req_tmr(req_tmr), .req_xfer(req_xfer), .req_any(req_any)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    wait_n(3);
    rst = 1'b0;
    // R1 reset values
    reg_rd(1'b0, rv); check("R1 flags", rv, 8'h30);
    reg_rd(1'b1, rv); check("R1 enables", rv, 8'h10);
    check("R1 req", {req_any, req_xfer, req_tmr, 1'b0, req_irq}, 8'h00);
    // R12 idle read
    #1 check("R12 idle", bus_rdata, 8'h00);

    // R2 rising edges per pin, R3 falling per pin
    for (int p = 0; p < 4; p++) begin
      irq_rise_sel = 4'hF;
      irq_pin[p] = 1'b1; wait_n(4);
      reg_rd(1'b0, rv); check("R2 rise sets", rv, 8'h30 | (8'h01 << p));
      irq_pin[p] = 1'b0; wait_n(4);
      reg_rd(1'b0, rv); check("R11 persists after fall", rv, 8'h30 | (8'h01 << p));
      reg_wr(1'b0, 8'h00);
      reg_rd(1'b0, rv); check("R6 clear", rv, 8'h30);
      irq_rise_sel[p] = 1'b0;
      irq_pin[p] = 1'b1; wait_n(4);
      reg_rd(1'b0, rv); check("R3 rise ignored", rv, 8'h30);
      irq_pin[p] = 1'b0; wait_n(4);
      reg_rd(1'b0, rv); check("R3 fall sets", rv, 8'h30 | (8'h01 << p));
      reg_wr(1'b0, 8'h00);
    end
    irq_rise_sel = 4'hF;

    // R4 timer: full count sweep, one wrap at the end
    for (int c = 0; c < 256; c++) begin
      @(negedge clk); tmr_count = 8'(c);
    end
    reg_rd(1'b0, rv); check("R4 no wrap yet", rv, 8'h30);
    @(negedge clk); tmr_count = 8'h00;
    reg_rd(1'b0, rv); check("R4 wrap sets", rv, 8'h70);
    reg_wr(1'b0, 8'h00);
    @(negedge clk); tmr_count = 8'hFF;
    @(negedge clk); tmr_count = 8'h01;
    reg_rd(1'b0, rv); check("R4 FF to 01 ignored", rv, 8'h30);
    @(negedge clk); tmr_count = 8'h00;
    reg_rd(1'b0, rv); check("R4 01 to 00 ignored", rv, 8'h30);

    // R5 direct transfer
    @(negedge clk); sleep_cmd = 1'b1; xfer_on = 1'b0;
    @(negedge clk); sleep_cmd = 1'b0;
    reg_rd(1'b0, rv); check("R5 sleep alone", rv, 8'h30);
    @(negedge clk); xfer_on = 1'b1;
    @(negedge clk); sleep_cmd = 1'b1;
    @(negedge clk); sleep_cmd = 1'b0; xfer_on = 1'b0;
    reg_rd(1'b0, rv); check("R5 xfer sets", rv, 8'hB0);

    // R6/R7 write patterns over all flags set
    for (int w = 0; w < 8; w++) begin
      logic [7:0] wd;
      wd = 8'(w * 37 + 5);
      irq_pin = 4'hF; wait_n(4); irq_pin = 4'h0; wait_n(4);
      @(negedge clk); tmr_count = 8'hFF;
      @(negedge clk); tmr_count = 8'h00; sleep_cmd = 1'b1; xfer_on = 1'b1;
      @(negedge clk); sleep_cmd = 1'b0; xfer_on = 1'b0;
      reg_rd(1'b0, rv); check("R6 all set", rv, 8'hFF);
      reg_wr(1'b0, wd);
      reg_rd(1'b0, rv); check("R6 R7 write pattern", rv, (8'hFF & (wd | 8'h30)) | 8'h30);
      reg_wr(1'b0, 8'h00);
    end

    // R8 set beats clear in same cycle
    irq_pin = 4'hF; wait_n(4); irq_pin = 4'h0; wait_n(4);
    @(negedge clk); sleep_cmd = 1'b1; xfer_on = 1'b1;
    @(negedge clk); sleep_cmd = 1'b0; xfer_on = 1'b0;
    @(negedge clk);
    bus_addr = 1'b0; bus_wdata = 8'h00; bus_wr = 1'b1; sleep_cmd = 1'b1; xfer_on = 1'b1;
    @(negedge clk); bus_wr = 1'b0; sleep_cmd = 1'b0; xfer_on = 1'b0;
    reg_rd(1'b0, rv); check("R8 xfer set wins", rv, 8'hB0);
    reg_wr(1'b0, 8'h00);
    @(negedge clk); tmr_count = 8'hFF;
    @(negedge clk);
    tmr_count = 8'h00; bus_addr = 1'b0; bus_wdata = 8'h00; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    reg_rd(1'b0, rv); check("R8 timer set wins", rv, 8'h70);

    // R9/R10 enable sweep with every flag set
    irq_pin = 4'hF; wait_n(4); irq_pin = 4'h0; wait_n(4);
    @(negedge clk); sleep_cmd = 1'b1; xfer_on = 1'b1;
    @(negedge clk); sleep_cmd = 1'b0; xfer_on = 1'b0;
    for (int e = 0; e < 16; e++) begin
      reg_wr(1'b1, 8'hE0 | 8'(e));
      tmr_ien = e[0]; xfer_ien = e[1];
      reg_rd(1'b1, rv); check("R9 enable readback", rv, 8'h10 | 8'(e));
      wait_n(2);
      check("R10 pin req", {4'h0, req_irq}, 8'(e));
      check("R10 src req", {6'h0, req_xfer, req_tmr}, {6'h0, e[1], e[0]});
      check("R10 any", {7'h0, req_any}, {7'h0, (e != 0)});
    end
    wait_n(20);
    reg_rd(1'b0, rv); check("R11 flags persist", rv, 8'hFF);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule